// File: doc/BRIEF.md
# SD/eMMC PHY Pad Bring-Up Sequencer

This block runs once after reset, on request, to bring a storage-interface PHY into a usable state. A single `start` pulse launches a fixed programme of accesses to the PHY's 8-bit indirect register file. The programme first turns on the I/O pads and trim. It then waits for the PHY to report that pad calibration has finished. After that it switches on the receivers, pull-ups and output drivers of the command, data, strobe and clock lines. It widens the clock-buffer selection and, as its last step, puts the PHY into its slow default signalling mode.

Most steps are read-modify-write: the current register value is read, a fixed mask is ORed in, and the result is written back, so bits the sequencer does not own are preserved. The calibration wait re-reads a status register until its ready bit appears, bounded by a cycle budget. A register access that returns a failure flag, or one that is never acknowledged, aborts the programme. The sequencer reports success with a one-cycle `done` pulse and failure with a sticky `err` flag.

Top module: `phy_pad_init_seq`

## Requirements
- R1: After reset, `done`, `err` and `reg_req` are low, and the register port stays idle until `start` is seen.
- R2: The first two steps are read-modify-writes that preserve all other bits. Address 0x01 gets bits 6 and 1 set (mask 0x42). Address 0x02 gets bit 1 set (mask 0x02).
- R3: Next, address 0x03 is read repeatedly until bit 4 (mask 0x10) reads as 1. No later step begins before that.
- R4: Nine read-modify-writes then follow, in this exact order as address/mask pairs: 0x06/0x03, 0x08/0x02, 0x20/0x01, 0x07/0xFF, 0x09/0xFF, 0x21/0xFF, 0x22/0x01, 0x23/0x01, 0x0F/0x07.
- R5: The last step writes 0x04 to address 0x11 with no read of that address. A successful run therefore issues exactly 12 writes in total.
- R6: Port handshake: `reg_req` is held, with `reg_addr`, `reg_we` and `reg_wdata` stable, until `reg_ack`. It drops in the cycle after the acknowledge, so there is at least one idle cycle between accesses. `reg_we`=1 marks a write.
- R7: An access acknowledged with `reg_fail`=1 aborts the programme: `err` rises and no further access is issued.
- R8: An access not acknowledged within ACK_WAIT cycles is dropped, and the programme aborts with `err`.
- R9: If bit 4 of address 0x03 has not been read as 1 once CLK_MHZ*POLL_US cycles of polling have passed, the programme aborts with `err`. None of the line-enable steps is performed.
- R10: On success, `done` is high for exactly one cycle and `err` stays low. `err`, once raised, stays high until the next accepted `start`, which clears it.
- R11: A `start` received while a programme is running is ignored: the run completes once, with the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the bring-up programme when idle |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Sticky abort flag, cleared by next start |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete (one cycle) |
| reg_fail | input | 1 | Access failed, valid with reg_ack |
| reg_rdata | input | 8 | Read data, valid with reg_ack |

## Verification
The assertions check the port protocol on every cycle. This covers the request being held stable until acknowledge, the gap after each acknowledge, and the rule that the mode register is never read and only ever receives 0x04. They also check that `done` is a single pulse that never coincides with `err`, that `err` is sticky, and that an access failure always leads to `err`. Other properties can only be shown by the bench's scenarios against a modelled register file with random contents and random latencies. These are the step order, the preservation of unowned bits, the gating of line-enable steps on calibration, both timeouts, and the ignored mid-run start.

// File: rtl/pinit_pkg.sv
package pinit_pkg;

  typedef enum logic [1:0] {
    OP_RMW  = 2'd0,
    OP_POLL = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] addr;
    logic [7:0] val;   // OR mask, poll mask or literal write value
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_RD_WAIT,
    S_WR_ISSUE,
    S_WR_WAIT
  } st_e;

  localparam int NUM_STEPS = 13;

  function automatic step_t step_at(input int unsigned idx);
    step_t s;
    case (idx)
      0:       s = '{OP_RMW,  8'h01, 8'h42};
      1:       s = '{OP_RMW,  8'h02, 8'h02};
      2:       s = '{OP_POLL, 8'h03, 8'h10};
      3:       s = '{OP_RMW,  8'h06, 8'h03};
      4:       s = '{OP_RMW,  8'h08, 8'h02};
      5:       s = '{OP_RMW,  8'h20, 8'h01};
      6:       s = '{OP_RMW,  8'h07, 8'hFF};
      7:       s = '{OP_RMW,  8'h09, 8'hFF};
      8:       s = '{OP_RMW,  8'h21, 8'hFF};
      9:       s = '{OP_RMW,  8'h22, 8'h01};
      10:      s = '{OP_RMW,  8'h23, 8'h01};
      11:      s = '{OP_RMW,  8'h0F, 8'h07};
      default: s = '{OP_WR,   8'h11, 8'h04};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pinit_step_rom.sv
module pinit_step_rom
  import pinit_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb step = step_at(32'(idx));
endmodule

// File: rtl/pinit_timer.sv
module pinit_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (en && (cnt != LIM)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/phy_pad_init_seq.sv
module phy_pad_init_seq
  import pinit_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int POLL_US  = 100,
  parameter int ACK_WAIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       done,
  output logic       err,
  output logic       reg_req,
  output logic       reg_we,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic       reg_ack,
  input  logic       reg_fail,
  input  logic [7:0] reg_rdata
);
  localparam int POLL_CYC = CLK_MHZ * POLL_US;
  localparam int IDX_W    = $clog2(NUM_STEPS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STEPS - 1);

  st_e              st;
  logic [IDX_W-1:0] idx;
  step_t            cur;
  logic             ack_exp, poll_exp;

  pinit_step_rom #(.IDX_W(IDX_W)) u_rom (.idx(idx), .step(cur));

  pinit_timer #(.LIMIT(ACK_WAIT)) u_ack_tmr (
    .clk(clk), .rst(rst),
    .clr((st == S_ISSUE) || (st == S_WR_ISSUE)),
    .en((st == S_RD_WAIT) || (st == S_WR_WAIT)),
    .expired(ack_exp)
  );

  pinit_timer #(.LIMIT(POLL_CYC)) u_poll_tmr (
    .clk(clk), .rst(rst),
    .clr((st == S_IDLE) || (cur.op != OP_POLL)),
    .en(1'b1),
    .expired(poll_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            err <= 1'b0;
            idx <= '0;
            st  <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          reg_req  <= 1'b1;
          reg_addr <= cur.addr;
          if (cur.op == OP_WR) begin
            reg_we    <= 1'b1;
            reg_wdata <= cur.val;
            st        <= S_WR_WAIT;
          end else begin
            reg_we    <= 1'b0;
            reg_wdata <= '0;
            st        <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            if (reg_fail) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else if (cur.op == OP_POLL) begin
              if ((reg_rdata & cur.val) != '0) begin
                idx <= idx + 1'b1;
                st  <= S_ISSUE;
              end else if (poll_exp) begin
                err <= 1'b1;
                st  <= S_IDLE;
              end else begin
                st <= S_ISSUE;
              end
            end else begin
              reg_wdata <= reg_rdata | cur.val;
              st        <= S_WR_ISSUE;
            end
          end else if (ack_exp) begin
            reg_req <= 1'b0;
            err     <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_WR_ISSUE: begin
          reg_req <= 1'b1;
          reg_we  <= 1'b1;
          st      <= S_WR_WAIT;
        end
        S_WR_WAIT: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            if (reg_fail) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else if (idx == LAST) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_ISSUE;
            end
          end else if (ack_exp) begin
            reg_req <= 1'b0;
            err     <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pinit_checker.sv
module pinit_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       done,
  input logic       err,
  input logic       reg_req,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_ack,
  input logic       reg_fail
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> (reg_req || err) && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)); // R6
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_ack |=> !reg_req); // R6
  AST_MODE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_we |-> reg_addr != 8'h11); // R5
  AST_MODE_VALUE: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_we && reg_addr == 8'h11 |-> reg_wdata == 8'h04); // R5
  AST_FAIL_ABORT: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_ack && reg_fail |=> err && !reg_req); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err && !start |=> err); // R10
endmodule

bind phy_pad_init_seq pinit_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_fail(reg_fail)
);

// File: tb/phy_pad_init_seq_test.sv
`timescale 1ns/1ps
module phy_pad_init_seq_test;
  localparam int POLL_CYC = 300;
  localparam int ACKW     = 16;

  logic clk = 0, rst = 1, start = 0;
  logic done, err, reg_req, reg_we;
  logic [7:0] reg_addr, reg_wdata;
  logic reg_ack = 0, reg_fail = 0;
  logic [7:0] reg_rdata = 0;

  phy_pad_init_seq #(.CLK_MHZ(1), .POLL_US(POLL_CYC), .ACK_WAIT(ACKW)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_fail(reg_fail), .reg_rdata(reg_rdata));

  always #5 clk = ~clk;

  logic [7:0] mem [0:255];
  logic [7:0] init_mem [0:255];
  logic [7:0] wlog_a [0:31];
  logic [7:0] wlog_d [0:31];
  int wr_cnt, rd11_cnt, acc_cnt, cal_need, cal_reads, fail_at, mute_at;
  int wait_cnt, cur_lat, done_cnt;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) if (!rst && done) done_cnt <= done_cnt + 1;

  function automatic logic [7:0] exp_addr(input int k);
    case (k)
      0: return 8'h01;  1: return 8'h02;  2: return 8'h06;  3: return 8'h08;
      4: return 8'h20;  5: return 8'h07;  6: return 8'h09;  7: return 8'h21;
      8: return 8'h22;  9: return 8'h23;  10: return 8'h0F; default: return 8'h11;
    endcase
  endfunction

  function automatic logic [7:0] exp_mask(input int k);
    case (k)
      0: return 8'h42;  1: return 8'h02;  2: return 8'h03;  3: return 8'h02;
      4: return 8'h01;  5: return 8'hFF;  6: return 8'hFF;  7: return 8'hFF;
      8: return 8'h01;  9: return 8'h01;  10: return 8'h07; default: return 8'h04;
    endcase
  endfunction

  // register-file model: random latency, optional failure or silence
  initial begin
    wait_cnt = 0; cur_lat = 0;
    forever begin
      @(negedge clk);
      if (reg_ack) begin
        reg_ack = 0; reg_fail = 0;
      end else if (reg_req) begin
        if (wait_cnt < cur_lat) wait_cnt++;
        else if (mute_at >= 0 && acc_cnt >= mute_at) ;
        else begin
          if (reg_we) begin
            mem[reg_addr] = reg_wdata;
            if (wr_cnt < 32) begin wlog_a[wr_cnt] = reg_addr; wlog_d[wr_cnt] = reg_wdata; end
            wr_cnt++;
          end else begin
            if (reg_addr == 8'h11) rd11_cnt++;
            if (reg_addr == 8'h03) begin
              cal_reads++;
              if (cal_reads >= cal_need) mem[3] = mem[3] | 8'h10;
            end
            reg_rdata = mem[reg_addr];
          end
          reg_fail = (acc_cnt == fail_at);
          reg_ack = 1;
          acc_cnt++;
          wait_cnt = 0;
          cur_lat = $urandom_range(0, 3);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input int need, input int fat, input int mat);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      if (i == 3) mem[i] = mem[i] & 8'hEF;
      init_mem[i] = mem[i];
    end
    wr_cnt = 0; rd11_cnt = 0; acc_cnt = 0; cal_reads = 0;
    cal_need = need; fail_at = fat; mute_at = mat;
  endtask

  // returns 1 if done seen, 0 if err seen; restart_at>0 pulses start mid-run
  task automatic run(input int restart_at, output int base, output bit ok_end);
    int t;
    base = done_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0;
    ok_end = 0;
    forever begin
      @(negedge clk); #1;
      t++;
      if (t == restart_at) start = 1;
      else start = 0;
      if (done_cnt != base) begin ok_end = 1; break; end
      if (err) break;
      if (t > 5000) begin
        check(0, "watchdog", t, 5000);
        break;
      end
    end
    start = 0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic check_success(input string tag, input int base);
    bit mem_ok, log_ok;
    logic [7:0] e;
    check(done_cnt - base == 1, {tag, " R10 done once"}, done_cnt - base, 1);
    check(err == 0, {tag, " R10 err low"}, err, 0);
    check(wr_cnt == 12, {tag, " R5 write count"}, wr_cnt, 12);
    check(rd11_cnt == 0, {tag, " R5 mode not read"}, rd11_cnt, 0);
    log_ok = 1;
    for (int k = 0; k < 12; k++) begin
      e = (k == 11) ? 8'h04 : (init_mem[exp_addr(k)] | exp_mask(k));
      if (wlog_a[k] !== exp_addr(k) || wlog_d[k] !== e) begin
        log_ok = 0;
        $display("FAIL %s R2/R4 write %0d actual=%0h:%0h expected=%0h:%0h",
                 tag, k, wlog_a[k], wlog_d[k], exp_addr(k), e);
      end
    end
    n_chk++; if (!log_ok) n_bad++;
    mem_ok = 1;
    for (int i = 0; i < 256; i++) begin
      e = init_mem[i];
      for (int k = 0; k < 11; k++) if (exp_addr(k) == 8'(i)) e = e | exp_mask(k);
      if (i == 8'h11) e = 8'h04;
      if (i == 3) e = e | 8'h10;
      if (mem[i] !== e) begin
        mem_ok = 0;
        $display("FAIL %s R2/R4 reg %0h actual=%0h expected=%0h", tag, i, mem[i], e);
      end
    end
    n_chk++; if (!mem_ok) n_bad++;
    check(cal_reads == cal_need, {tag, " R3 poll reads"}, cal_reads, cal_need);
  endtask

  initial begin
    int base;
    bit ok;
    void'($urandom(32'd2024));
    done_cnt = 0;
    setup(1, -1, -1);
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    check(done == 0 && err == 0 && reg_req == 0, "R1 reset outputs", {done, err, reg_req}, 0);
    check(acc_cnt == 0, "R1 port idle", acc_cnt, 0);

    // directed: calibration ready on first read
    setup(1, -1, -1);
    run(0, base, ok);
    check_success("first-read-cal", base);

    // random runs with varying calibration delay and latency
    for (int n = 0; n < 6; n++) begin
      setup($urandom_range(2, 12), -1, -1);
      run(0, base, ok);
      check_success("random", base);
    end

    // R9 calibration never completes
    setup(1000000, -1, -1);
    run(0, base, ok);
    check(err == 1 && !ok, "R9 poll timeout err", err, 1);
    check(wr_cnt == 2, "R9 only pad writes", wr_cnt, 2);
    check(mem[8'h06] == init_mem[8'h06], "R9 line reg untouched", mem[8'h06], init_mem[8'h06]);
    check(cal_reads > 3, "R3 polling repeated", cal_reads, 4);
    repeat (20) @(negedge clk); #1;
    check(err == 1 && reg_req == 0, "R10 err sticky", err, 1);

    // R7 failure on the first access
    setup(1, 0, -1);
    run(0, base, ok);
    check(err == 1 && acc_cnt == 1 && wr_cnt == 0, "R7 fail first access", acc_cnt, 1);

    // R7 failure on the write of the first line step (access 6)
    setup(1, 6, -1);
    run(0, base, ok);
    check(err == 1 && acc_cnt == 7 && done_cnt == base, "R7 fail mid access", acc_cnt, 7);

    // R8 no acknowledge from access 2 on
    setup(1, -1, 2);
    run(0, base, ok);
    check(err == 1 && wr_cnt == 1, "R8 ack timeout", wr_cnt, 1);
    repeat (30) @(negedge clk); #1;
    check(reg_req == 0, "R8 request dropped", reg_req, 0);

    // R10 err cleared by a fresh start, then success
    setup(3, -1, -1);
    run(0, base, ok);
    check_success("after-error", base);

    // R11 start pulsed mid-run is ignored
    setup(4, -1, -1);
    run(25, base, ok);
    check_success("R11 restart-ignored", base);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule